// File: doc/BRIEF.md
# Receiver Control Line Sequencer

This block drives eight control lines of a radio front end through a timed power-up walk. A host writes 32-bit packets, one per `pkt_valid` pulse. Each setting packet fills one slot of a small settings store with three fields: a line pattern, a wait code counted in 625 µs steps, and a flag that asks for a battery check.

A pulse on `seq_start` makes the block visit the slots in ascending order. In each slot it drives that slot's pattern and holds it for the programmed number of steps. If the slot's flag is set, the battery-status input is captured at the edge where the block leaves the slot. The host may also force any line to a fixed level. Forced lines ignore the sequencer until their force bit is cleared. While reset is asserted every line is released (output enable low).

A parameterised prescaler turns the system clock into the 625 µs step, so `TICK_DIV` is the number of clock cycles in one step.

Top module: `rxline_sequencer`

## Requirements
- R1: While `rst_n` is low, `line_oe` is 0 and `line_o` is 0. From the first clock edge after reset release, `line_oe` is all ones. After reset every slot holds wait code 01h, pattern 00h and flag 0, and no line is forced.
- R2: A setting packet has byte 3 (bits 31:24) equal to 16h+k, which selects slot k for k = 0..3. Slot 0 is the 3200 sps sync state, slot 1 the 1600 sps sync state, slot 2 the 3200 sps data state and slot 3 the 1600 sps data state. Bit 20 is the flag, bits 15:8 are the pattern and bits 6:0 are the wait code. All other bits are ignored.
- R3: `seq_start` while idle begins the walk at slot 0, one clock edge later. The walk visits slots in ascending order. During a slot, unforced lines carry that slot's pattern. After the last slot, unforced lines return to 0.
- R4: Each slot lasts exactly code × `TICK_DIV` clock cycles. The step prescaler restarts at every slot entry.
- R5: A wait code of 00h behaves as 01h.
- R6: When a flagged slot is left, `batt_stat` takes the value of `batt_low` sampled at that edge and `batt_done` becomes 1. A slot without the flag leaves `batt_stat` unchanged. `seq_start` clears `batt_done`.
- R7: An override packet has byte 3 equal to 0Fh and byte 2 equal to 00h. Byte 1 is the force mask and byte 0 is the forced levels. A line whose force bit is 1 drives its level from the cycle after the write. A line whose force bit is 0 follows the sequencer.
- R8: A packet with any other byte-3 value, or with ID 0Fh and a nonzero byte 2, changes nothing.
- R9: `seq_start` while a walk is running is ignored. The walk keeps its timing.
- R10: `busy` is 1 from the cycle after an accepted start until the last slot ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Packet strobe, one packet per cycle |
| pkt_data | input | 32 | Packet; byte 3 is the ID |
| seq_start | input | 1 | Begin a receiver-on walk |
| batt_low | input | 1 | Battery status input |
| line_o | output | 8 | Control line levels |
| line_oe | output | 8 | Control line output enables (0 = high impedance) |
| busy | output | 1 | Walk in progress |
| batt_stat | output | 1 | Last captured battery status |
| batt_done | output | 1 | A battery capture happened since the last start |

## Verification
All outputs come from registers. A packet shows on the lines in the first cycle after its edge. A start raises `busy` and shows slot 0's pattern one edge later. A slot change and a battery capture both land exactly code × `TICK_DIV` edges after that slot was entered. The bench's behavioural model advances on the same edges, and every output is compared at the falling edge, which keeps sampling clear of the update. Separate directed checks count `busy` cycles over whole walks, so that the slot timing is confirmed apart from the model.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
   typedef struct packed {
      logic       chk;
      logic [7:0] pat;
      logic [6:0] code;
   } rxl_slot_t;

   localparam logic [7:0] RXL_OVR_ID = 8'h0F;

   function automatic logic [6:0] rxl_eff_code(input logic [6:0] c);
      return (c == 7'd0) ? 7'd1 : c;
   endfunction
endpackage

// File: rtl/rxl_tick.sv
module rxl_tick #(
   parameter int DIV = 62500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [W-1:0] LAST = W'(DIV - 1);

   logic [W-1:0] cnt;

   assign tick = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (tick)   cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end

   // R4: the divider never runs past its last count
   a_r4_div_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
endmodule

// File: rtl/rxl_store.sv
module rxl_store
   import rxl_pkg::*;
#(
   parameter int         N_SLOTS = 4,
   parameter logic [7:0] BASE_ID = 8'h16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pkt_valid,
   input  logic [31:0]             pkt_data,
   output rxl_slot_t [N_SLOTS-1:0] slots,
   output logic [7:0]              frc_mask,
   output logic [7:0]              frc_lvl
);
   logic [7:0] id;
   logic       ovr_hit;
   assign id      = pkt_data[31:24];
   assign ovr_hit = pkt_valid && (id == RXL_OVR_ID) && (pkt_data[23:16] == 8'h00);

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      logic hit;
      assign hit = pkt_valid && (id == BASE_ID + 8'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slots[g] <= '{chk: 1'b0, pat: 8'h00, code: 7'h01};
         end else if (hit) begin
            slots[g] <= '{chk: pkt_data[20], pat: pkt_data[15:8], code: pkt_data[6:0]};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frc_mask <= 8'h00;
         frc_lvl  <= 8'h00;
      end else if (ovr_hit) begin
         frc_mask <= pkt_data[15:8];
         frc_lvl  <= pkt_data[7:0];
      end
   end

   // R7: an override write lands in the next cycle
   a_r7_ovr_load: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && pkt_data[31:16] == 16'h0F00)
      |=> (frc_mask == $past(pkt_data[15:8]) && frc_lvl == $past(pkt_data[7:0])));

   // R8: a packet outside every known ID leaves the store untouched
   a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && pkt_data[31:24] != 8'h0F
       && (pkt_data[31:24] < BASE_ID || pkt_data[31:24] >= BASE_ID + 8'(N_SLOTS)))
      |=> ($stable(slots) && $stable(frc_mask) && $stable(frc_lvl)));
endmodule

// File: rtl/rxl_stepper.sv
module rxl_stepper
   import rxl_pkg::*;
#(
   parameter int N_SLOTS = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    tick,
   input  logic                    batt_low,
   input  rxl_slot_t [N_SLOTS-1:0] slots,
   output logic                    busy,
   output logic [7:0]              pat,
   output logic                    bstat,
   output logic                    bdone
);
   localparam int IW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
   localparam logic [IW-1:0] LAST_IDX = IW'(N_SLOTS - 1);

   logic [IW-1:0] idx;
   logic [6:0]    step;
   logic [IW-1:0] nxt;
   assign nxt = idx + 1'b1;

   assign pat = busy ? slots[idx].pat : 8'h00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         idx   <= '0;
         step  <= 7'd1;
         bstat <= 1'b0;
         bdone <= 1'b0;
      end else if (!busy && start) begin
         busy  <= 1'b1;
         idx   <= '0;
         step  <= rxl_eff_code(slots[0].code);
         bdone <= 1'b0;
      end else if (busy && tick) begin
         if (step == 7'd1) begin
            if (slots[idx].chk) begin
               bstat <= batt_low;
               bdone <= 1'b1;
            end
            if (idx == LAST_IDX) begin
               busy <= 1'b0;
            end else begin
               idx  <= nxt;
               step <= rxl_eff_code(slots[nxt].code);
            end
         end else begin
            step <= step - 1'b1;
         end
      end
   end

   // R5: the step counter never holds zero during a walk
   a_r5_step_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> step != 7'd0);

   // R6: a capture only comes from a running walk
   a_r6_done_src: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bdone) |-> $past(busy));

   // R3: slots are visited in ascending order
   a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && idx != $past(idx)) |-> idx == $past(idx) + 1'b1);

   // R9: without a step tick nothing moves, start included
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> ($stable(idx) && $stable(step) && busy));
endmodule

// File: rtl/rxline_sequencer.sv
module rxline_sequencer
   import rxl_pkg::*;
#(
   parameter int         N_SLOTS  = 4,
   parameter logic [7:0] BASE_ID  = 8'h16,
   parameter int         TICK_DIV = 62500
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        pkt_valid,
   input  logic [31:0] pkt_data,
   input  logic        seq_start,
   input  logic        batt_low,
   output logic [7:0]  line_o,
   output logic [7:0]  line_oe,
   output logic        busy,
   output logic        batt_stat,
   output logic        batt_done
);
   if (N_SLOTS < 1 || N_SLOTS > 16) begin : g_bad_slots
      $error("N_SLOTS must lie in 1..16");
   end
   if (TICK_DIV < 1) begin : g_bad_div
      $error("TICK_DIV must be at least 1");
   end
   if (int'(BASE_ID[3:0]) + N_SLOTS > 16) begin : g_bad_base
      $error("slot IDs must stay inside one ID nibble");
   end

   rxl_slot_t [N_SLOTS-1:0] slots;
   logic [7:0] frc_mask, frc_lvl, seq_pat;
   logic       tick, oe_q;

   rxl_store #(.N_SLOTS(N_SLOTS), .BASE_ID(BASE_ID)) u_store (
      .clk, .rst_n, .pkt_valid, .pkt_data,
      .slots, .frc_mask, .frc_lvl);

   rxl_tick #(.DIV(TICK_DIV)) u_tick (
      .clk, .rst_n, .run(busy), .tick);

   rxl_stepper #(.N_SLOTS(N_SLOTS)) u_step (
      .clk, .rst_n, .start(seq_start), .tick, .batt_low, .slots,
      .busy, .pat(seq_pat), .bstat(batt_stat), .bdone(batt_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= 1'b1;
   end

   assign line_oe = {8{oe_q}};
   assign line_o  = oe_q ? ((frc_mask & frc_lvl) | (~frc_mask & seq_pat)) : 8'h00;

   // R10: busy rises only on an accepted start
   a_r10_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(seq_start));
endmodule

// File: tb/sim_rxline_sequencer.sv
module sim_rxline_sequencer;
   localparam int D = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        pkt_valid = 1'b0;
   logic [31:0] pkt_data = '0;
   logic        seq_start = 1'b0;
   logic        batt_low = 1'b0;
   logic [7:0]  line_o, line_oe;
   logic        busy, batt_stat, batt_done;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   rxline_sequencer #(.TICK_DIV(D)) u0 (
      .clk, .rst_n, .pkt_valid, .pkt_data, .seq_start, .batt_low,
      .line_o, .line_oe, .busy, .batt_stat, .batt_done);

   // behavioural reference
   int m_pat [4];
   int m_code[4];
   int m_chk [4];
   int m_frc, m_lvl, m_oe, m_busy, m_idx, m_div, m_step, m_bs, m_bd;

   function automatic int eff(input int c);
      return (c == 0) ? 1 : c;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin m_pat[i] = 0; m_code[i] = 1; m_chk[i] = 0; end
         m_frc = 0; m_lvl = 0; m_oe = 0; m_busy = 0; m_idx = 0;
         m_div = 0; m_step = 1; m_bs = 0; m_bd = 0;
      end else begin
         automatic int ob = m_busy;
         automatic bit tk = (m_busy != 0) && (m_div == D - 1);
         m_oe = 1;
         if (!ob && seq_start) begin
            m_busy = 1; m_idx = 0; m_step = eff(m_code[0]); m_bd = 0;
         end else if (ob && tk) begin
            if (m_step == 1) begin
               if (m_chk[m_idx] != 0) begin m_bs = batt_low; m_bd = 1; end
               if (m_idx == 3) m_busy = 0;
               else begin m_idx++; m_step = eff(m_code[m_idx]); end
            end else m_step--;
         end
         if (!ob || tk) m_div = 0; else m_div++;
         if (pkt_valid) begin
            if (pkt_data[31:24] >= 8'h16 && pkt_data[31:24] <= 8'h19) begin
               automatic int k = int'(pkt_data[31:24]) - 'h16;
               m_chk[k] = pkt_data[20]; m_pat[k] = pkt_data[15:8]; m_code[k] = pkt_data[6:0];
            end else if (pkt_data[31:16] == 16'h0F00) begin
               m_frc = pkt_data[15:8]; m_lvl = pkt_data[7:0];
            end
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison at the falling edge
   always @(negedge clk) begin
      automatic int sp = m_busy ? m_pat[m_idx] : 0;
      automatic int el = m_oe ? (((m_frc & m_lvl) | (~m_frc & sp)) & 8'hFF) : 0;
      chk("R3 lines", line_o, el);
      chk("R1 oe", line_oe, m_oe ? 8'hFF : 8'h00);
      chk("R10 busy", busy, m_busy);
      chk("R6 stat", batt_stat, m_bs);
      chk("R6 done", batt_done, m_bd);
   end

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic send(input logic [31:0] w);
      @(negedge clk); pkt_valid = 1'b1; pkt_data = w;
      @(negedge clk); pkt_valid = 1'b0; pkt_data = '0;
   endtask

   // start a walk, count busy cycles; optional second start mid-walk, battery pattern
   task automatic walk(input bit restart, input int bmode, output int n);
      n = 0;
      @(negedge clk); seq_start = 1'b1;
      @(negedge clk); seq_start = 1'b0;
      while (busy) begin
         n++;
         seq_start = (restart && n == 5);
         if (bmode == 2) batt_low = n[1];
         @(negedge clk);
      end
      seq_start = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      int n;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 oe in reset", line_oe, 8'h00);
      chk("R1 lines in reset", line_o, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 oe after reset", line_oe, 8'hFF);
      chk("R1 idle lines", line_o, 8'h00);

      // R4: default codes of 1 give D cycles per slot
      walk(1'b0, 0, n);
      chk("R4 default walk length", n, 4 * D);

      // R2 slot programming, junk bits ignored; R5 code 0 as 1
      send(32'h1600_A502);
      send(32'h1710_3C00);           // R5 code 0
      send(32'h18EF_0F83);           // flag clear, junk bits, code 3
      send(32'h1910_F081);           // bit 7 junk, code 1
      batt_low = 1'b1;
      walk(1'b0, 0, n);
      chk("R5 R4 programmed walk length", n, (2 + 1 + 3 + 1) * D);
      chk("R6 capture high", batt_stat, 1);
      chk("R6 done set", batt_done, 1);

      // R9: restart mid-walk ignored, battery toggling
      walk(1'b1, 2, n);
      chk("R9 walk length with extra start", n, 7 * D);
      batt_low = 1'b0;

      // R7 override
      send(32'h0F00_F0A0);
      chk("R7 forced upper nibble", line_o, 8'hA0);
      walk(1'b0, 0, n);
      send(32'h0F00_FF5A);
      chk("R7 all lines forced", line_o, 8'h5A);

      // R8 dropped packets
      send(32'h0F01_0000);
      chk("R8 bad byte2 ignored", line_o, 8'h5A);
      send(32'h1A10_FF7F);
      send(32'h1500_FF7F);
      send(32'h0F00_0000);
      chk("R7 override released", line_o, 8'h00);
      walk(1'b0, 0, n);
      chk("R8 slots unchanged by stray IDs", n, 7 * D);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule